// File: doc/BRIEF.md
# Legacy I/O Configuration Header Decoder

This block decodes byte addresses in the first I/O region of a transitional paravirtual device. The region holds the older fixed configuration header. Fixed offsets select the 32-bit feature words, the per-queue address and size, the queue select and notify fields, the device status byte and the interrupt status byte. When MSI-X is enabled, two 16-bit vector fields are inserted after the header. Every offset past the header goes to the device-specific window, which is passed through to the device logic with its offset rebased to zero.

The layout changes while the device runs. The `msix_en` input moves the start of the device-specific window from byte 20 to byte 24, and the change takes effect in the same cycle. Header fields respond only to naturally sized, aligned accesses. The window accepts any width and forwards the access size unchanged. Per-queue state (ring address and vector) is held in small arrays that can map to block RAM, indexed by the queue select register.

Top module: `legacy_cfg_hdr`

## Requirements
- R1: A read request (`io_valid`=1, `io_write`=0) is answered one clock later with `io_rvalid`=1 for one cycle. Read data is right-aligned in `io_rdata`. A write, or an idle cycle, gives `io_rvalid`=0 in the next cycle.
- R2: Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit. A 32-bit read at byte 0 returns `dev_features`. A 32-bit access at byte 4 reads and writes the driver feature word. `drv_features[31:0]` shows the last value written and `drv_features[63:32]` is always 0.
- R3: A 16-bit access at byte 14 reads and writes the queue select. A 16-bit read at byte 12 returns QUEUE_DEPTH when the select is below NUM_QUEUES and 0 otherwise. Writes to byte 12 are dropped.
- R4: A 32-bit access at byte 8 reads and writes the page-frame ring address of the selected queue. Each queue keeps its own value. When the select is out of range, writes are dropped and reads return 0.
- R5: A 16-bit write at byte 16 raises `notify_valid` for exactly the next cycle, with `notify_queue` equal to the written value. Reads of byte 16 return 0.
- R6: A byte access at byte 18 reads and writes the device status. `dev_status` shows that value from the cycle after the write.
- R7: With MSI-X off, a byte read at byte 19 returns the interrupt status and clears it. Bits on `isr_set` are ORed into the status each cycle, and a bit set in the same cycle as the clearing read is kept.
- R8: With MSI-X on, a byte read at byte 19 returns 0 and leaves the interrupt status unchanged.
- R9: With MSI-X on, a 16-bit access at byte 20 reads and writes the config vector (`config_vector`). A 16-bit access at byte 22 reads and writes the vector of the selected queue, which is dropped or reads 0 when the select is out of range.
- R10: The device-specific window starts at byte 20 with MSI-X off and at byte 24 with it on. A window access drives `win_valid` in the same cycle, together with `win_offset` = address minus window start, the size unchanged and the write data. A read returns the `win_rdata` value sampled at that edge.
- R11: A header access that is not at a field's own offset with its own size is dropped on write and returns 0 on read.
- R12: Turning MSI-X off takes effect in the same cycle. Bytes 20 to 23 then reach the window as offsets 0 to 3 and no longer reach the vector fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Access request this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | Byte address within the I/O region |
| io_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| io_wdata | input | 32 | Right-aligned write data |
| io_rvalid | output | 1 | Read data valid |
| io_rdata | output | 32 | Right-aligned read data |
| msix_en | input | 1 | MSI-X enabled in the function |
| dev_features | input | 32 | Device-offered feature bits 0 to 31 |
| isr_set | input | 8 | Interrupt status bits to set |
| drv_features | output | 64 | Driver-acknowledged feature bits |
| dev_status | output | 8 | Device status register |
| config_vector | output | 16 | Config change vector |
| notify_valid | output | 1 | Queue notification pulse |
| notify_queue | output | 16 | Notified queue index |
| win_valid | output | 1 | Device-specific window access |
| win_write | output | 1 | Window access is a write |
| win_offset | output | ADDR_W | Offset within the window |
| win_size | output | 2 | Window access size |
| win_wdata | output | 32 | Window write data |
| win_rdata | input | 32 | Window read data, same cycle |

## Verification
Two timings apply. The window handshake is combinational, so `win_valid`, `win_offset`, `win_size` and the write data are checked within the request cycle, just before the rising edge. Header read data, `io_rvalid`, the notify pulse and the updated `dev_status` and `drv_features` all appear one edge after the request. Inputs are driven on the falling edge and the results are sampled on the following falling edge. The bench model applies register writes and interrupt status changes at that same edge, so each expected value is computed from the state that existed before the access.

// File: rtl/lgh_pkg.sv
package lgh_pkg;

  typedef enum logic [3:0] {
    FLD_NONE,
    FLD_DEVFEAT,
    FLD_DRVFEAT,
    FLD_QADDR,
    FLD_QSIZE,
    FLD_QSEL,
    FLD_QNOTIFY,
    FLD_STATUS,
    FLD_ISR,
    FLD_CFGVEC,
    FLD_QVEC,
    FLD_WINDOW
  } field_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // byte offsets; the decoder and the driver both depend on them
  localparam int OFS_DEVFEAT   = 0;
  localparam int OFS_DRVFEAT   = 4;
  localparam int OFS_QADDR     = 8;
  localparam int OFS_QSIZE     = 12;
  localparam int OFS_QSEL      = 14;
  localparam int OFS_QNOTIFY   = 16;
  localparam int OFS_STATUS    = 18;
  localparam int OFS_ISR       = 19;
  localparam int OFS_CFGVEC    = 20;
  localparam int OFS_QVEC      = 22;
  localparam int WIN_BASE_STD  = 20;
  localparam int WIN_BASE_MSIX = 24;

endpackage

// File: rtl/lgh_addr_decode.sv
module lgh_addr_decode
  import lgh_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              msix_on,
  output field_e            field,
  output logic [ADDR_W-1:0] win_off
);

  localparam logic [ADDR_W-1:0] A_DEVFEAT = ADDR_W'(OFS_DEVFEAT);
  localparam logic [ADDR_W-1:0] A_DRVFEAT = ADDR_W'(OFS_DRVFEAT);
  localparam logic [ADDR_W-1:0] A_QADDR   = ADDR_W'(OFS_QADDR);
  localparam logic [ADDR_W-1:0] A_QSIZE   = ADDR_W'(OFS_QSIZE);
  localparam logic [ADDR_W-1:0] A_QSEL    = ADDR_W'(OFS_QSEL);
  localparam logic [ADDR_W-1:0] A_QNOTIFY = ADDR_W'(OFS_QNOTIFY);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ISR     = ADDR_W'(OFS_ISR);
  localparam logic [ADDR_W-1:0] A_CFGVEC  = ADDR_W'(OFS_CFGVEC);
  localparam logic [ADDR_W-1:0] A_QVEC    = ADDR_W'(OFS_QVEC);
  localparam logic [ADDR_W-1:0] B_STD     = ADDR_W'(WIN_BASE_STD);
  localparam logic [ADDR_W-1:0] B_MSIX    = ADDR_W'(WIN_BASE_MSIX);

  logic [ADDR_W-1:0] base;

  always_comb begin
    base    = msix_on ? B_MSIX : B_STD;
    field   = FLD_NONE;
    win_off = '0;
    if (addr >= base) begin
      field   = FLD_WINDOW;
      win_off = addr - base;
    end else begin
      case (addr)
        A_DEVFEAT: if (size == SZ_WORD) field = FLD_DEVFEAT;
        A_DRVFEAT: if (size == SZ_WORD) field = FLD_DRVFEAT;
        A_QADDR:   if (size == SZ_WORD) field = FLD_QADDR;
        A_QSIZE:   if (size == SZ_HALF) field = FLD_QSIZE;
        A_QSEL:    if (size == SZ_HALF) field = FLD_QSEL;
        A_QNOTIFY: if (size == SZ_HALF) field = FLD_QNOTIFY;
        A_STATUS:  if (size == SZ_BYTE) field = FLD_STATUS;
        A_ISR:     if (size == SZ_BYTE) field = FLD_ISR;
        A_CFGVEC:  if (msix_on && size == SZ_HALF) field = FLD_CFGVEC;
        A_QVEC:    if (msix_on && size == SZ_HALF) field = FLD_QVEC;
        default:   field = FLD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/lgh_queue_store.sv
module lgh_queue_store #(
  parameter int NUM_QUEUES = 4,
  parameter int ADDR_BITS  = 32,
  parameter int VEC_BITS   = 16,
  localparam int QIDX_W    = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                 clk,
  input  logic                 wr_addr_en,
  input  logic                 wr_vec_en,
  input  logic [QIDX_W-1:0]    wr_idx,
  input  logic [ADDR_BITS-1:0] wdata,
  input  logic [QIDX_W-1:0]    rd_idx,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic [VEC_BITS-1:0]  rd_vec
);

  // one write port and one registered read port per array, block RAM style
  logic [ADDR_BITS-1:0] addr_mem [NUM_QUEUES];
  logic [VEC_BITS-1:0]  vec_mem  [NUM_QUEUES];

  always_ff @(posedge clk) begin
    if (wr_addr_en) addr_mem[wr_idx] <= wdata;
    rd_addr <= addr_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (wr_vec_en) vec_mem[wr_idx] <= wdata[VEC_BITS-1:0];
    rd_vec <= vec_mem[rd_idx];
  end

endmodule

// File: rtl/lgh_isr_reg.sv
module lgh_isr_reg #(
  parameter int ISR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ISR_W-1:0] set_bits,
  input  logic             clear,
  output logic [ISR_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst)        value <= '0;
    else if (clear) value <= set_bits;
    else            value <= value | set_bits;
  end

endmodule

// File: rtl/legacy_cfg_hdr.sv
module legacy_cfg_hdr
  import lgh_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_QUEUES  = 4,
  parameter int QUEUE_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic [31:0]       io_wdata,
  output logic              io_rvalid,
  output logic [31:0]       io_rdata,
  input  logic              msix_en,
  input  logic [31:0]       dev_features,
  input  logic [7:0]        isr_set,
  output logic [63:0]       drv_features,
  output logic [7:0]        dev_status,
  output logic [15:0]       config_vector,
  output logic              notify_valid,
  output logic [15:0]       notify_queue,
  output logic              win_valid,
  output logic              win_write,
  output logic [ADDR_W-1:0] win_offset,
  output logic [1:0]        win_size,
  output logic [31:0]       win_wdata,
  input  logic [31:0]       win_rdata
);

  localparam int QIDX_W = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
  localparam logic [15:0] QLIMIT = 16'(NUM_QUEUES);
  localparam logic [31:0] QDEPTH = 32'(QUEUE_DEPTH);

  field_e            fld;
  logic [ADDR_W-1:0] woff;
  logic              rd_req, wr_req, qsel_ok;
  logic [31:0]       drv_q;
  logic [7:0]        status_q;
  logic [15:0]       qsel_q, cfgvec_q, notq_q;
  logic              notv_q, rvalid_q, rqok_q;
  field_e            rfield_q;
  logic [31:0]       rsimple_q, simple_rd;
  logic [31:0]       qaddr_rd;
  logic [15:0]       qvec_rd;
  logic [7:0]        isr_val;
  logic              isr_clear;

  assign rd_req  = io_valid & ~io_write;
  assign wr_req  = io_valid &  io_write;
  assign qsel_ok = qsel_q < QLIMIT;

  lgh_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (io_addr),
    .size    (io_size),
    .msix_on (msix_en),
    .field   (fld),
    .win_off (woff)
  );

  lgh_queue_store #(.NUM_QUEUES(NUM_QUEUES), .ADDR_BITS(32), .VEC_BITS(16)) u_qstore (
    .clk        (clk),
    .wr_addr_en (wr_req && fld == FLD_QADDR && qsel_ok),
    .wr_vec_en  (wr_req && fld == FLD_QVEC && qsel_ok),
    .wr_idx     (qsel_q[QIDX_W-1:0]),
    .wdata      (io_wdata),
    .rd_idx     (qsel_q[QIDX_W-1:0]),
    .rd_addr    (qaddr_rd),
    .rd_vec     (qvec_rd)
  );

  assign isr_clear = rd_req && fld == FLD_ISR && !msix_en;

  lgh_isr_reg #(.ISR_W(8)) u_isr (
    .clk      (clk),
    .rst      (rst),
    .set_bits (isr_set),
    .clear    (isr_clear),
    .value    (isr_val)
  );

  // window pass-through in the request cycle
  assign win_valid  = io_valid && fld == FLD_WINDOW;
  assign win_write  = io_write;
  assign win_offset = woff;
  assign win_size   = io_size;
  assign win_wdata  = io_wdata;

  always_comb begin
    case (fld)
      FLD_DEVFEAT: simple_rd = dev_features;
      FLD_DRVFEAT: simple_rd = drv_q;
      FLD_QSIZE:   simple_rd = qsel_ok ? QDEPTH : 32'd0;
      FLD_QSEL:    simple_rd = {16'd0, qsel_q};
      FLD_STATUS:  simple_rd = {24'd0, status_q};
      FLD_ISR:     simple_rd = msix_en ? 32'd0 : {24'd0, isr_val};
      FLD_CFGVEC:  simple_rd = {16'd0, cfgvec_q};
      FLD_WINDOW:  simple_rd = win_rdata;
      default:     simple_rd = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q     <= '0;
      status_q  <= '0;
      qsel_q    <= '0;
      cfgvec_q  <= '0;
      notv_q    <= 1'b0;
      notq_q    <= '0;
      rvalid_q  <= 1'b0;
      rqok_q    <= 1'b0;
      rfield_q  <= FLD_NONE;
      rsimple_q <= '0;
    end else begin
      rvalid_q <= rd_req;
      notv_q   <= wr_req && fld == FLD_QNOTIFY;
      if (wr_req) begin
        case (fld)
          FLD_DRVFEAT: drv_q    <= io_wdata;
          FLD_QSEL:    qsel_q   <= io_wdata[15:0];
          FLD_QNOTIFY: notq_q   <= io_wdata[15:0];
          FLD_STATUS:  status_q <= io_wdata[7:0];
          FLD_CFGVEC:  cfgvec_q <= io_wdata[15:0];
          default: ;
        endcase
      end
      if (rd_req) begin
        rfield_q  <= fld;
        rqok_q    <= qsel_ok;
        rsimple_q <= simple_rd;
      end
    end
  end

  always_comb begin
    case (rfield_q)
      FLD_QADDR: io_rdata = rqok_q ? qaddr_rd : 32'd0;
      FLD_QVEC:  io_rdata = rqok_q ? {16'd0, qvec_rd} : 32'd0;
      default:   io_rdata = rsimple_q;
    endcase
  end

  assign io_rvalid     = rvalid_q;
  assign drv_features  = {32'd0, drv_q};
  assign dev_status    = status_q;
  assign config_vector = cfgvec_q;
  assign notify_valid  = notv_q;
  assign notify_queue  = notq_q;

endmodule

// File: rtl/legacy_cfg_hdr_chk.sv
module legacy_cfg_hdr_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              io_valid,
  input logic              io_write,
  input logic [ADDR_W-1:0] io_addr,
  input logic [1:0]        io_size,
  input logic [31:0]       io_wdata,
  input logic              io_rvalid,
  input logic [31:0]       io_rdata,
  input logic              msix_en,
  input logic [7:0]        dev_status,
  input logic              notify_valid,
  input logic [15:0]       notify_queue,
  input logic              win_valid,
  input logic [ADDR_W-1:0] win_offset
);

  p_read_answer_r1: assert property (@(posedge clk) disable iff (rst)
    (io_valid && !io_write) |=> io_rvalid);

  p_no_spurious_rvalid_r1: assert property (@(posedge clk) disable iff (rst)
    !(io_valid && !io_write) |=> !io_rvalid);

  p_notify_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_write && io_addr == ADDR_W'(16) && io_size == 2'd1)
    |=> (notify_valid && notify_queue == $past(io_wdata[15:0])));

  p_notify_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !(io_valid && io_write && io_addr == ADDR_W'(16) && io_size == 2'd1)
    |=> !notify_valid);

  p_status_write_r6: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_write && io_addr == ADDR_W'(18) && io_size == 2'd0)
    |=> dev_status == $past(io_wdata[7:0]));

  p_bad_width_r11: assert property (@(posedge clk) disable iff (rst)
    (io_valid && !io_write && io_addr == ADDR_W'(0) && io_size != 2'd2)
    |=> io_rdata == 32'd0);

  p_window_plain_r12: assert property (@(posedge clk) disable iff (rst)
    (!msix_en && io_valid && io_addr >= ADDR_W'(20))
    |-> (win_valid && win_offset == io_addr - ADDR_W'(20)));

  p_window_msix_r10: assert property (@(posedge clk) disable iff (rst)
    (msix_en && io_valid && io_addr >= ADDR_W'(20) && io_addr < ADDR_W'(24))
    |-> !win_valid);

endmodule

bind legacy_cfg_hdr legacy_cfg_hdr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .io_valid     (io_valid),
  .io_write     (io_write),
  .io_addr      (io_addr),
  .io_size      (io_size),
  .io_wdata     (io_wdata),
  .io_rvalid    (io_rvalid),
  .io_rdata     (io_rdata),
  .msix_en      (msix_en),
  .dev_status   (dev_status),
  .notify_valid (notify_valid),
  .notify_queue (notify_queue),
  .win_valid    (win_valid),
  .win_offset   (win_offset)
);

// File: tb/legacy_cfg_hdr_bench.sv
`timescale 1ns/1ps
module legacy_cfg_hdr_bench;

  localparam int AW = 8;
  localparam int NQ = 4;
  localparam int QD = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          io_valid = 1'b0, io_write = 1'b0;
  logic [AW-1:0] io_addr = '0;
  logic [1:0]    io_size = '0;
  logic [31:0]   io_wdata = '0;
  logic          io_rvalid;
  logic [31:0]   io_rdata;
  logic          msix_en = 1'b0;
  logic [31:0]   dev_features = 32'h3A5C_0F81;
  logic [7:0]    isr_set = '0;
  logic [63:0]   drv_features;
  logic [7:0]    dev_status;
  logic [15:0]   config_vector;
  logic          notify_valid;
  logic [15:0]   notify_queue;
  logic          win_valid, win_write;
  logic [AW-1:0] win_offset;
  logic [1:0]    win_size;
  logic [31:0]   win_wdata;
  logic [31:0]   win_rdata;

  assign win_rdata = {24'hC0DE00, win_offset};

  always #4 clk = ~clk;

  legacy_cfg_hdr #(.ADDR_W(AW), .NUM_QUEUES(NQ), .QUEUE_DEPTH(QD)) u_legacy_cfg_hdr (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
    .io_size(io_size), .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
    .msix_en(msix_en), .dev_features(dev_features), .isr_set(isr_set),
    .drv_features(drv_features), .dev_status(dev_status), .config_vector(config_vector),
    .notify_valid(notify_valid), .notify_queue(notify_queue), .win_valid(win_valid),
    .win_write(win_write), .win_offset(win_offset), .win_size(win_size),
    .win_wdata(win_wdata), .win_rdata(win_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  logic [31:0] m_drv, m_qaddr [NQ];
  logic [15:0] m_qsel, m_cfgvec, m_qvec [NQ];
  logic [7:0]  m_status, m_isr;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int win_base(input logic mx);
    return mx ? 24 : 20;
  endfunction

  function automatic string tag_of(input int a, input logic mx);
    if (a >= win_base(mx)) return (mx ? "R10" : "R12");
    case (a)
      0, 4: return "R2";
      8: return "R4";
      12, 14: return "R3";
      16: return "R5";
      18: return "R6";
      19: return (mx ? "R8" : "R7");
      20, 22: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input int a, input logic [1:0] sz, input logic mx);
    logic ok;
    ok = m_qsel < NQ;
    if (a >= win_base(mx)) return {24'hC0DE00, 8'(a - win_base(mx))};
    if (a == 0  && sz == 2) return dev_features;
    if (a == 4  && sz == 2) return m_drv;
    if (a == 8  && sz == 2) return ok ? m_qaddr[m_qsel[1:0]] : 32'd0;
    if (a == 12 && sz == 1) return ok ? 32'(QD) : 32'd0;
    if (a == 14 && sz == 1) return {16'd0, m_qsel};
    if (a == 18 && sz == 0) return {24'd0, m_status};
    if (a == 19 && sz == 0) return mx ? 32'd0 : {24'd0, m_isr};
    if (a == 20 && sz == 1 && mx) return {16'd0, m_cfgvec};
    if (a == 22 && sz == 1 && mx) return ok ? {16'd0, m_qvec[m_qsel[1:0]]} : 32'd0;
    return 32'd0;
  endfunction

  task automatic access(input logic we, input int a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [7:0] iset);
    logic [31:0] exp;
    logic        in_win, ok, clr, notif;
    string       tg;
    @(negedge clk);
    io_valid = 1'b1; io_write = we; io_addr = AW'(a); io_size = sz;
    io_wdata = wd; isr_set = iset;
    exp    = exp_read(a, sz, msix_en);
    in_win = a >= win_base(msix_en);
    tg     = tag_of(a, msix_en);
    #1;
    check(in_win ? "R10 window strobe" : "R10 no window strobe", {63'd0, win_valid}, {63'd0, in_win});
    if (in_win) begin
      check("R10 window offset/size", {54'd0, win_offset, win_size},
            {54'd0, 8'(a - win_base(msix_en)), sz});
      if (we) check("R10 window wdata", {32'd0, win_wdata}, {32'd0, wd});
    end
    @(posedge clk);
    ok = m_qsel < NQ;
    clr = !we && a == 19 && sz == 0 && !msix_en;
    notif = we && a == 16 && sz == 1;
    if (we && !in_win) begin
      if (a == 4 && sz == 2) m_drv = wd;
      if (a == 8 && sz == 2 && ok) m_qaddr[m_qsel[1:0]] = wd;
      if (a == 14 && sz == 1) m_qsel = wd[15:0];
      if (a == 18 && sz == 0) m_status = wd[7:0];
      if (a == 20 && sz == 1 && msix_en) m_cfgvec = wd[15:0];
      if (a == 22 && sz == 1 && msix_en && ok) m_qvec[m_qsel[1:0]] = wd[15:0];
    end
    m_isr = (clr ? 8'd0 : m_isr) | iset;
    @(negedge clk);
    io_valid = 1'b0; isr_set = '0;
    check("R1 rvalid", {63'd0, io_rvalid}, {63'd0, !we});
    if (!we) check({tg, " read data"}, {32'd0, io_rdata}, {32'd0, exp});
    check("R5 notify strobe", {63'd0, notify_valid}, {63'd0, notif});
    if (notif) check("R5 notify queue", {48'd0, notify_queue}, {48'd0, wd[15:0]});
    check("R6 status out", {56'd0, dev_status}, {56'd0, m_status});
    check("R2 driver features out", drv_features, {32'd0, m_drv});
    check("R9 config vector out", {48'd0, config_vector}, {48'd0, m_cfgvec});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int pick_ofs [10] = '{0, 4, 8, 12, 14, 16, 18, 19, 20, 22};
    void'($urandom(32'd20240611));
    m_drv = 0; m_qsel = 0; m_cfgvec = 0; m_status = 0; m_isr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // reset state
    check("R1 reset rvalid", {63'd0, io_rvalid}, 64'd0);
    check("R6 reset status", {56'd0, dev_status}, 64'd0);
    check("R2 reset driver features", drv_features, 64'd0);
    check("R5 reset notify", {63'd0, notify_valid}, 64'd0);
    // give every queue a known address and vector
    msix_en = 1'b1;
    for (int q = 0; q < NQ; q++) begin
      access(1, 14, 1, q, 0);
      access(1, 8, 2, 32'h0001_0000 + q, 0);
      access(1, 22, 1, 16'h0100 + q, 0);
    end
    // directed: per-queue readback and out-of-range select
    access(1, 14, 1, 2, 0);
    access(0, 8, 2, 0, 0);          // R4 queue 2 address
    access(0, 12, 1, 0, 0);         // R3 size in range
    access(1, 12, 1, 16'h0011, 0);  // R3 write dropped
    access(0, 12, 1, 0, 0);
    access(1, 14, 1, NQ, 0);
    access(0, 12, 1, 0, 0);         // R3 size 0 out of range
    access(1, 8, 2, 32'hDEAD, 0);   // R4 dropped
    access(0, 8, 2, 0, 0);
    access(0, 22, 1, 0, 0);         // R9 out of range reads 0
    access(1, 14, 1, 1, 0);
    access(0, 22, 1, 0, 0);         // R9 queue 1 vector
    // R2 features, R11 width mismatch
    access(0, 0, 2, 0, 0);
    access(1, 4, 2, 32'hCAFE_F00D, 0);
    access(1, 4, 1, 32'h1234, 0);   // R11 dropped
    access(0, 4, 2, 0, 0);
    access(0, 0, 1, 0, 0);          // R11 reads 0
    access(0, 5, 0, 0, 0);          // R11 misaligned
    // R5 notify, R6 status
    access(1, 16, 1, 16'h0003, 0);
    access(0, 16, 1, 0, 0);
    access(1, 18, 0, 8'h0F, 0);
    access(0, 18, 0, 0, 0);
    // R8: msix on, ISR reads 0 and keeps bits
    access(0, 0, 2, 0, 8'h05);
    access(0, 19, 0, 0, 0);
    access(1, 20, 1, 16'h0042, 0);
    access(0, 20, 1, 0, 0);
    access(0, 24, 2, 0, 0);         // R10 window at 24
    access(1, 27, 0, 32'h77, 0);
    // R12 / R7: msix off
    msix_en = 1'b0;
    access(0, 20, 1, 0, 0);         // window offset 0
    access(0, 22, 2, 0, 0);         // window offset 2, any width
    access(0, 19, 0, 0, 8'h20);     // R7 returns 05, keeps new 20
    access(0, 19, 0, 0, 0);         // R7 returns 20
    access(0, 19, 0, 0, 0);         // R7 returns 0
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int a;
      logic [1:0] sz;
      logic [31:0] wd;
      logic [7:0] is;
      if ($urandom % 16 == 0) msix_en = ~msix_en;
      a  = ($urandom % 4 == 0) ? int'($urandom % 32) : pick_ofs[$urandom % 10];
      sz = 2'($urandom % 3);
      wd = $urandom;
      if (a == 14) wd = $urandom % (NQ + 2);
      is = ($urandom % 4 == 0) ? 8'($urandom) : 8'd0;
      access(1'($urandom % 2), a, sz, wd, is);
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule